// File: doc/BRIEF.md
# Up/Down PWM Timer with Compare Output, Hardware Trip and ADC Trigger

This block is a general-purpose timer for motor-control PWM. A counter runs up from zero to a programmed period and back down to zero, without stopping. One compare output follows where the count sits relative to a compare value. The output polarity is programmable, and it can also be forced to a fixed level.

The compare pin is presented as a data value plus an output enable, for a tri-state pad. When the trip function is armed, an active-low trip input turns the pad off. The trip also clears the software output-enable bit and latches a protect flag, so the fault stays visible.

A two-bit selector picks which timer event produces a one-clock ADC start pulse. This keeps phase-current sampling locked to the PWM carrier. Period and compare writes go to buffer registers and only reach the active copies at the bottom of the carrier, so a PWM period never glitches.

All register traffic uses a plain single-cycle port. A write strobe carries an address and data. The read data is a combinational function of the address. There is no handshake and no back-pressure: every write lands on the clock edge where `wr_en` is high.

Top module: `pwm_cmp_timer`

## Requirements
- R1: While control bit 6 (run) is 1 and the active period P is non-zero, the count steps by one each clock: 0,1,…,P,P-1,…,0,1,… and so on. With run at 0 or P at 0, the count is held at 0.
- R2: Status bit 0 (address 3) and the `cnt_dir` pin read 1 while counting up and 0 while counting down. The bit turns 0 in the cycle the count reaches P and turns 1 in the cycle it reaches 0. It reads 1 while stopped.
- R3: Writes to address 0 (period) and address 1 (compare) only fill buffers. The active copies, read back at addresses 5 and 6, take the buffer values on the edge where the count steps down to 0, and on every edge while run is 0.
- R4: Control bits [3:2] select the ADC trigger: 00 never, 01 count reaches 0, 10 count reaches P, 11 count reaches the active compare value in either direction. `adc_start` is high for exactly the one clock in which the count holds that value.
- R5: Control bits [1:0] set the pin polarity: 00 drives 0, 11 drives 1, 10 drives the compare state, 01 drives its inverse.
- R6: The compare state becomes 1 in the cycle an up-count reaches the compare value, and 0 in the cycle a down-count reaches it. It is 0 while stopped, so a compare of 0 or a compare above P keeps it 0.
- R7: `cmp_oe` is high only while control bit 4 (output enable) is 1 and no trip is active. When it is low the pad is high impedance.
- R8: While control bit 5 (trip enable) is 1 and `trip_n` is 0, `cmp_oe` is low in the same cycle. On the next edge the output-enable bit clears and the protect flag (status bit 1, `prot_flag`) sets. The flag stays set until a write of 1 to status bit 1; a trip in the same cycle wins. The enable bit stays 0 until software writes it again.
- R9: With trip enable at 0, `trip_n` changes neither `cmp_oe`, nor the output-enable bit, nor the protect flag.
- R10: Reads return: 0 period buffer, 1 compare buffer, 2 control bits [6:0], 3 status, 4 count, 5 active period, 6 active compare, 7 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| trip_n | input | 1 | Active-low hardware trip |
| cmp_drv | output | 1 | Compare pin data value |
| cmp_oe | output | 1 | Compare pin output enable (0 = high impedance) |
| adc_start | output | 1 | One-clock ADC start pulse |
| prot_flag | output | 1 | Sticky power-drive-protect flag |
| cnt_dir | output | 1 | Count direction, 1 = up |

## Verification
The bench goes after the turning points of the carrier: period values of 1 and 0, compare values of 0, equal to P and above P, and period writes landing mid-carrier. A design that loaded its shadow registers early would show a new period or compare value before the count reached zero. A design that set direction one cycle late would report up at the peak.

Trips are driven in the same cycle as a write that clears the flag, and again as a write that re-enables the output. This catches a design where software can override a live fault. A trip with trip enable off is applied as well, which would expose any design that still gates or latches on an ignored trip.

ADC selector changes are exercised around events. An off-by-one trigger would pulse a cycle away from the count that the readback shows.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    POL_LOW    = 2'b00,
    POL_ACT_LO = 2'b01,
    POL_ACT_HI = 2'b10,
    POL_HIGH   = 2'b11
  } pol_e;

  typedef enum logic [1:0] {
    TRG_NONE  = 2'b00,
    TRG_ZERO  = 2'b01,
    TRG_PEAK  = 2'b10,
    TRG_MATCH = 2'b11
  } trg_sel_e;

  // bit 6 run, bit 5 trip enable, bit 4 output enable, [3:2] trigger, [1:0] polarity
  typedef struct packed {
    logic     run;
    logic     trip_en;
    logic     oe;
    trg_sel_e trg;
    pol_e     pol;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic zero;
    logic peak;
    logic match;
    logic match_up;
  } evt_t;

  localparam logic [2:0] A_PER     = 3'd0;
  localparam logic [2:0] A_CMP     = 3'd1;
  localparam logic [2:0] A_CTRL    = 3'd2;
  localparam logic [2:0] A_STAT    = 3'd3;
  localparam logic [2:0] A_CNT     = 3'd4;
  localparam logic [2:0] A_PER_ACT = 3'd5;
  localparam logic [2:0] A_CMP_ACT = 3'd6;

  localparam int STAT_DIR_BIT  = 0;
  localparam int STAT_FLAG_BIT = 1;

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] per_buf,
  input  logic [W-1:0] cmp_buf,
  input  trg_sel_e     trg,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic [W-1:0] per_act,
  output logic [W-1:0] cmp_act,
  output evt_t         evt,
  output logic         adc_start
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_n;
  logic         dir_q, dir_n;
  logic [W-1:0] per_q, cmp_q;
  logic         load;
  logic         trg_hit;
  logic         adc_q;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    evt   = '0;
    if (!run || per_q == '0) begin
      cnt_n = '0;
      dir_n = 1'b1;
    end else if (dir_q) begin
      cnt_n = cnt_q + ONE;
      if (cnt_n == per_q) begin
        dir_n    = 1'b0;
        evt.peak = 1'b1;
      end
    end else begin
      cnt_n = cnt_q - ONE;
      if (cnt_n == '0) begin
        dir_n    = 1'b1;
        evt.zero = 1'b1;
      end
    end
    if (run && per_q != '0 && cnt_n == cmp_q) begin
      evt.match    = 1'b1;
      evt.match_up = dir_q;
    end
  end

  assign load = !run || evt.zero;

  always_comb begin
    unique case (trg)
      TRG_ZERO:  trg_hit = evt.zero;
      TRG_PEAK:  trg_hit = evt.peak;
      TRG_MATCH: trg_hit = evt.match;
      default:   trg_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      per_q <= '0;
      cmp_q <= '0;
      adc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
      adc_q <= trg_hit;
      if (load) begin
        per_q <= per_buf;
        cmp_q <= cmp_buf;
      end
    end
  end

  assign cnt       = cnt_q;
  assign dir_up    = dir_q;
  assign per_act   = per_q;
  assign cmp_act   = cmp_q;
  assign adc_start = adc_q;

endmodule

// File: rtl/pwmt_cmp_out.sv
module pwmt_cmp_out
  import pwmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  evt_t evt,
  input  pol_e pol,
  input  logic oe_bit,
  input  logic trip_act,
  output logic drv,
  output logic oe
);

  logic state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
    end else if (!run) begin
      state_q <= 1'b0;
    end else if (evt.match) begin
      state_q <= evt.match_up;
    end
  end

  always_comb begin
    unique case (pol)
      POL_LOW:    drv = 1'b0;
      POL_ACT_LO: drv = ~state_q;
      POL_ACT_HI: drv = state_q;
      default:    drv = 1'b1;
    endcase
  end

  // trip acts on the pad without waiting for a clock edge
  assign oe = oe_bit & ~trip_act;

endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  input  logic         trip_act,
  input  logic [W-1:0] cnt,
  input  logic         dir_up,
  input  logic [W-1:0] per_act,
  input  logic [W-1:0] cmp_act,
  output logic [W-1:0] per_buf,
  output logic [W-1:0] cmp_buf,
  output ctrl_t        ctrl,
  output logic         flag,
  output logic [W-1:0] rd_data
);

  logic [W-1:0] per_q, cmp_q;
  ctrl_t        ctrl_q, ctrl_n;
  logic         flag_q;
  logic         clr_req;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en && addr == A_CTRL) ctrl_n = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (trip_act) ctrl_n.oe = 1'b0;
  end

  assign clr_req = wr_en && addr == A_STAT && wr_data[STAT_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      cmp_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_PER) per_q <= wr_data;
      if (wr_en && addr == A_CMP) cmp_q <= wr_data;
      ctrl_q <= ctrl_n;
      if (trip_act)     flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_PER:     rd_data = per_q;
      A_CMP:     rd_data = cmp_q;
      A_CTRL:    rd_data = {{(W-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:    rd_data = {{(W-2){1'b0}}, flag_q, dir_up};
      A_CNT:     rd_data = cnt;
      A_PER_ACT: rd_data = per_act;
      A_CMP_ACT: rd_data = cmp_act;
      default:   rd_data = '0;
    endcase
  end

  assign per_buf = per_q;
  assign cmp_buf = cmp_q;
  assign ctrl    = ctrl_q;
  assign flag    = flag_q;

endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         trip_n,
  output logic         cmp_drv,
  output logic         cmp_oe,
  output logic         adc_start,
  output logic         prot_flag,
  output logic         cnt_dir
);

  ctrl_t        ctrl;
  logic [W-1:0] per_buf, cmp_buf, per_act, cmp_act, cnt;
  evt_t         evt;
  logic         trip_act;

  assign trip_act = ctrl.trip_en & ~trip_n;

  pwmt_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .trip_act (trip_act),
    .cnt      (cnt),
    .dir_up   (cnt_dir),
    .per_act  (per_act),
    .cmp_act  (cmp_act),
    .per_buf  (per_buf),
    .cmp_buf  (cmp_buf),
    .ctrl     (ctrl),
    .flag     (prot_flag),
    .rd_data  (rd_data)
  );

  pwmt_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl.run),
    .per_buf   (per_buf),
    .cmp_buf   (cmp_buf),
    .trg       (ctrl.trg),
    .cnt       (cnt),
    .dir_up    (cnt_dir),
    .per_act   (per_act),
    .cmp_act   (cmp_act),
    .evt       (evt),
    .adc_start (adc_start)
  );

  pwmt_cmp_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.run),
    .evt      (evt),
    .pol      (ctrl.pol),
    .oe_bit   (ctrl.oe),
    .trip_act (trip_act),
    .drv      (cmp_drv),
    .oe       (cmp_oe)
  );

endmodule

// File: rtl/pwm_cmp_timer_chk.sv
module pwm_cmp_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic [W-1:0] per_act,
  input logic [W-1:0] cnt,
  input logic         cnt_dir,
  input logic         adc_start,
  input logic [1:0]   trg,
  input logic         trip_en,
  input logic         trip_n,
  input logic         oe_bit,
  input logic         cmp_oe,
  input logic         prot_flag,
  input logic         zero_ev
);

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && per_act != '0 |-> cnt <= per_act);

  p_dir_peak_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && per_act != '0 && cnt == per_act |-> !cnt_dir);

  p_dir_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 |-> cnt_dir);

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && run && !$past(zero_ev) |-> $stable(per_act));

  p_adc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start && $past(trg) == 2'b01 |-> cnt == '0);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_bit |-> !cmp_oe);

  p_trip_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_en && !trip_n |-> !cmp_oe);

  p_trip_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_en && !trip_n |=> prot_flag && !oe_bit);

  p_trip_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_en && oe_bit |-> cmp_oe);

endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (ctrl.run),
  .per_act   (per_act),
  .cnt       (cnt),
  .cnt_dir   (cnt_dir),
  .adc_start (adc_start),
  .trg       (ctrl.trg),
  .trip_en   (ctrl.trip_en),
  .trip_n    (trip_n),
  .oe_bit    (ctrl.oe),
  .cmp_oe    (cmp_oe),
  .prot_flag (prot_flag),
  .zero_ev   (evt.zero)
);

// File: tb/pwm_cmp_timer_tb.sv
module pwm_cmp_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] rd_data;
  logic        trip_n = 1'b1;
  logic        cmp_drv, cmp_oe, adc_start, prot_flag, cnt_dir;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [15:0] m_cnt, m_pa, m_ca, m_pb, m_cb;
  logic        m_dir, m_st, m_flag, m_adc;
  logic [6:0]  m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .trip_n(trip_n), .cmp_drv(cmp_drv), .cmp_oe(cmp_oe),
    .adc_start(adc_start), .prot_flag(prot_flag), .cnt_dir(cnt_dir)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_pb;
      3'd1: return m_cb;
      3'd2: return {9'd0, m_ctrl};
      3'd3: return {14'd0, m_flag, m_dir};
      3'd4: return m_cnt;
      3'd5: return m_pa;
      3'd6: return m_ca;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic m_drv();
    case (m_ctrl[1:0])
      2'b00: return 1'b0;
      2'b01: return ~m_st;
      2'b10: return m_st;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    if (a == 3'd5 || a == 3'd6) return "R3 active readback";
    if (a == 3'd4) return "R1 count";
    return "R10 readback";
  endfunction

  task automatic check_all();
    chk("R2 direction", {15'd0, cnt_dir}, {15'd0, m_dir});
    chk("R4 adc_start", {15'd0, adc_start}, {15'd0, m_adc});
    chk("R5 R6 cmp_drv", {15'd0, cmp_drv}, {15'd0, m_drv()});
    chk("R7 R8 R9 cmp_oe", {15'd0, cmp_oe},
        {15'd0, m_ctrl[4] & ~(m_ctrl[5] & ~trip_n)});
    chk("R8 prot_flag", {15'd0, prot_flag}, {15'd0, m_flag});
    chk(rd_tag(addr), rd_data, m_read(addr));
  endtask

  // one clock: advance reference with current inputs, then compare
  task automatic cyc();
    logic        run, tr, zero, peak, match, up, hit;
    logic [15:0] cn;
    logic        dn;
    run = m_ctrl[6];
    tr  = m_ctrl[5] & ~trip_n;
    zero = 0; peak = 0; match = 0; up = 0;
    cn = m_cnt; dn = m_dir;
    if (!run || m_pa == 16'd0) begin
      cn = 16'd0; dn = 1'b1;
    end else if (m_dir) begin
      cn = m_cnt + 16'd1;
      if (cn == m_pa) begin dn = 1'b0; peak = 1; end
    end else begin
      cn = m_cnt - 16'd1;
      if (cn == 16'd0) begin dn = 1'b1; zero = 1; end
    end
    if (run && m_pa != 16'd0 && cn == m_ca) begin match = 1; up = m_dir; end
    case (m_ctrl[3:2])
      2'b01: hit = zero;
      2'b10: hit = peak;
      2'b11: hit = match;
      default: hit = 1'b0;
    endcase
    @(posedge clk);
    #1;
    m_adc = hit;
    if (!run) m_st = 1'b0; else if (match) m_st = up;
    if (!run || zero) begin m_pa = m_pb; m_ca = m_cb; end
    m_cnt = cn; m_dir = dn;
    if (wr_en && addr == 3'd0) m_pb = wr_data;
    if (wr_en && addr == 3'd1) m_cb = wr_data;
    if (wr_en && addr == 3'd2) m_ctrl = wr_data[6:0];
    if (tr) m_ctrl[4] = 1'b0;
    if (tr) m_flag = 1'b1;
    else if (wr_en && addr == 3'd3 && wr_data[1]) m_flag = 1'b0;
    check_all();
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d, input logic tn);
    wr_en = we; addr = a; wr_data = d; trip_n = tn;
    cyc();
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) step(1'b0, a, 16'd0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int r;
    void'($urandom(32'd20240611));
    m_cnt = 0; m_pa = 0; m_ca = 0; m_pb = 0; m_cb = 0;
    m_dir = 1; m_st = 0; m_flag = 0; m_adc = 0; m_ctrl = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state, all addresses
    for (int a = 0; a < 8; a++) begin
      addr = a[2:0]; #1;
      chk("R10 reset readback", rd_data, m_read(a[2:0]));
    end
    chk("R1 reset cmp_oe", {15'd0, cmp_oe}, 16'd0);
    chk("R2 reset direction up", {15'd0, cnt_dir}, 16'd1);

    // carrier P=5, compare 2, active high, trigger at zero
    step(1, 3'd0, 16'd5, 1);
    step(1, 3'd1, 16'd2, 1);
    step(1, 3'd2, 16'h0056, 1);
    idle(14, 3'd4);
    // mid-carrier period change must wait for zero
    step(1, 3'd0, 16'd9, 1);
    chk("R3 active period held", m_read(3'd5), 16'd5);
    idle(30, 3'd5);
    // period 1, trigger at peak, active low
    step(1, 3'd0, 16'd1, 1);
    step(1, 3'd2, 16'h0059, 1);
    idle(20, 3'd4);
    // compare above period and compare 0 keep state low
    step(1, 3'd1, 16'd20, 1);
    step(1, 3'd2, 16'h005E, 1);
    idle(12, 3'd6);
    step(1, 3'd1, 16'd0, 1);
    idle(12, 3'd3);
    // period 0 holds count
    step(1, 3'd0, 16'd0, 1);
    idle(25, 3'd4);
    chk("R1 period zero holds", rd_data, 16'd0);

    // trip: armed, forced-high polarity
    step(1, 3'd0, 16'd6, 1);
    step(1, 3'd2, 16'h0073, 1);
    idle(4, 3'd2);
    step(0, 3'd2, 16'd0, 0);
    chk("R8 oe bit cleared", rd_data & 16'h0010, 16'h0000);
    chk("R8 flag set", {15'd0, prot_flag}, 16'd1);
    step(0, 3'd2, 16'd0, 1);
    chk("R8 oe stays low after trip release", {15'd0, cmp_oe}, 16'd0);
    // clear and trip in same cycle: trip wins
    step(1, 3'd3, 16'h0002, 0);
    chk("R8 trip beats clear", {15'd0, prot_flag}, 16'd1);
    step(1, 3'd3, 16'h0002, 1);
    chk("R8 flag cleared by write", {15'd0, prot_flag}, 16'd0);
    // re-enable while tripping: stays off
    step(1, 3'd2, 16'h0073, 0);
    chk("R8 enable write loses to trip", rd_data & 16'h0010, 16'h0000);
    step(1, 3'd3, 16'h0002, 1);
    // trip disabled: ignored
    step(1, 3'd2, 16'h0053, 1);
    step(0, 3'd3, 16'd0, 0);
    chk("R9 oe kept with trip disabled", {15'd0, cmp_oe}, 16'd1);
    chk("R9 flag untouched", {15'd0, prot_flag}, 16'd0);
    idle(3, 3'd2);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      r = $urandom % 100;
      if (r < 6) begin
        d = (($urandom % 50) == 0) ? 16'd0 : 16'($urandom % 12 + 1);
        step(1, 3'd0, d, ($urandom % 20) != 0);
      end else if (r < 12) begin
        step(1, 3'd1, 16'($urandom % 15), ($urandom % 20) != 0);
      end else if (r < 16) begin
        d = 16'($urandom % 128);
        if (($urandom % 10) != 0) d[6] = 1'b1;
        if (($urandom % 3) != 0) d[4] = 1'b1;
        step(1, 3'd2, d, ($urandom % 20) != 0);
      end else if (r < 19) begin
        step(1, 3'd3, 16'($urandom % 4), ($urandom % 20) != 0);
      end else begin
        step(0, 3'($urandom % 8), 16'd0, ($urandom % 25) != 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule